// File: doc/BRIEF.md
# Cache Maintenance Range Splitter

The splitter accepts one cache maintenance request at a time, described by a kind, a byte start address and an exclusive byte end address. It breaks the request into a stream of commands for a downstream range maintenance engine. The engine expects line-aligned bounds with an inclusive upper address. Three request kinds are supported: invalidate, clean, and flush. A flush is a clean followed by an invalidate.

Invalidate requests need special handling for lines that are only partly covered. Each partial line at either edge is sent as a single-line clean-and-invalidate, so that bytes outside the request are not lost. All other lines are sent as range commands. Every range command stays inside one page and covers at most a fixed number of bytes. A write-through input suppresses every clean command, because a write-through cache never holds dirty lines.

Commands leave over a valid/ready handshake. A one-cycle done pulse marks the end of every request. The upstream side sees a ready signal that is high only while the splitter is idle.

Top module: `maint_splitter`

## Requirements
- R1: After reset, req_ready_o is 1, and cmd_valid_o and done_o are 0.
- R2: Request kind codes are 0 invalidate, 1 clean and 2 flush. Command op codes are 0 single-line clean-and-invalidate (cmd_lo_o equals cmd_hi_o, both the line address), 1 clean range and 2 invalidate range.
- R3: For an invalidate whose start is not 32-byte aligned, the first command is op 0 for the line holding the start address. The working start then moves up to the next line boundary.
- R4: For an invalidate whose end is not aligned, op 0 is issued for the line holding the end address. This happens only if the working start is still below the end, and it comes after any R3 command. The working end is then rounded down to a line boundary.
- R5: For clean and flush, the start is rounded down and the end is rounded up to 32-byte boundaries before splitting.
- R6: Full lines are sent as chunks from the working start. Each chunk ends (exclusive) at the smallest of three values: the working end, the start plus 1024, and the next 4096-byte page boundary above the start. A range command carries the chunk start and the chunk end minus 32, both line-aligned.
- R7: A range command never spans two 4 KiB pages and never covers more than 1024 bytes.
- R8: In a flush, each chunk produces a clean range command and then an invalidate range command with identical bounds.
- R9: When wt_i is 1 at request acceptance, a clean request issues no commands, and a flush issues only its invalidate range commands.
- R10: done_o pulses high for exactly one cycle after the last command of every request is accepted. It pulses even when no command is issued at all, for example when the aligned start equals the aligned end. The splitter is idle in the following cycle.
- R11: A command held with cmd_ready_i low keeps its op and bounds unchanged. req_ready_o is 0 from acceptance until done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Splitter idle, request accepted |
| req_kind_i | input | 2 | Request kind (R2) |
| req_start_i | input | ADDR_W | First byte address |
| req_end_i | input | ADDR_W | Exclusive end byte address |
| wt_i | input | 1 | Write-through override, sampled at acceptance |
| cmd_valid_o | output | 1 | Command present |
| cmd_ready_i | input | 1 | Engine takes command |
| cmd_op_o | output | 2 | Command op (R2) |
| cmd_lo_o | output | ADDR_W | Inclusive start address of command |
| cmd_hi_o | output | ADDR_W | Inclusive end address of command |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the edge lines of invalidate requests. It includes a request that fits inside a single line, where only the start edge may be issued; a design that tested the end edge before rounding the start would emit a duplicate line command. Requests that cross pages and exceed 1024 bytes expose a chunk limit that uses only one of its caps: such a design would cross a page or emit an oversized range. Flush and clean are run with and without write-through, to catch clean commands that leak or invalidates that go missing. Empty aligned requests check that done still pulses. Random back-pressure on cmd_ready_i checks that commands hold steady and are neither dropped nor repeated.

// File: rtl/maint_splitter_pkg.sv
package maint_splitter_pkg;
  typedef enum logic [1:0] {
    KIND_INV   = 2'd0,
    KIND_CLEAN = 2'd1,
    KIND_FLUSH = 2'd2
  } req_kind_e;

  typedef enum logic [1:0] {
    OP_LINE_CI   = 2'd0,
    OP_CLEAN_RNG = 2'd1,
    OP_INV_RNG   = 2'd2
  } cmd_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EDGE_LO,
    ST_EDGE_HI,
    ST_CLEAN,
    ST_INV,
    ST_DONE
  } split_state_e;
endpackage

// File: rtl/maint_split_align.sv
module maint_split_align #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] end_i,
  output logic              need_lo_o,
  output logic              need_hi_o,
  output logic [ADDR_W-1:0] lo_line_o,
  output logic [ADDR_W-1:0] hi_line_o,
  output logic [ADDR_W:0]   start_al_o,
  output logic [ADDR_W:0]   end_al_o
);
  import maint_splitter_pkg::*;

  localparam logic [ADDR_W:0] LMASK = (ADDR_W+1)'(LINE_BYTES - 1);

  logic [ADDR_W:0] s_w, e_w, s_up, s_dn, e_up, e_dn;
  logic            s_part, e_part;

  always_comb begin
    s_w    = {1'b0, start_i};
    e_w    = {1'b0, end_i};
    s_part = |(s_w & LMASK);
    e_part = |(e_w & LMASK);
    s_dn   = s_w & ~LMASK;
    e_dn   = e_w & ~LMASK;
    s_up   = s_part ? (s_w | LMASK) + 1'b1 : s_w;
    e_up   = (e_w + LMASK) & ~LMASK;
    lo_line_o = start_i & ~LMASK[ADDR_W-1:0];
    hi_line_o = end_i & ~LMASK[ADDR_W-1:0];
    if (kind_i == KIND_INV) begin
      need_lo_o  = s_part;
      need_hi_o  = (s_up < e_w) && e_part;
      start_al_o = s_up;
      end_al_o   = need_hi_o ? e_dn : e_w;
    end else begin
      need_lo_o  = 1'b0;
      need_hi_o  = 1'b0;
      start_al_o = s_dn;
      end_al_o   = e_up;
    end
  end
endmodule

// File: rtl/maint_split_chunk.sv
module maint_split_chunk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int MAX_BYTES  = 1024,
  parameter int PAGE_BYTES = 4096
) (
  input  logic [ADDR_W:0]   cur_i,
  input  logic [ADDR_W:0]   fin_i,
  output logic [ADDR_W:0]   chunk_end_o,
  output logic [ADDR_W-1:0] incl_hi_o
);
  localparam logic [ADDR_W:0] PMASK = (ADDR_W+1)'(PAGE_BYTES - 1);
  localparam logic [ADDR_W:0] MAXW  = (ADDR_W+1)'(MAX_BYTES);
  localparam logic [ADDR_W:0] LINEW = (ADDR_W+1)'(LINE_BYTES);

  logic [ADDR_W:0] by_len, by_page, m1, incl_w;

  always_comb begin
    by_len      = cur_i + MAXW;
    by_page     = (cur_i | PMASK) + 1'b1;
    m1          = (fin_i < by_len) ? fin_i : by_len;
    chunk_end_o = (m1 < by_page) ? m1 : by_page;
    incl_w      = chunk_end_o - LINEW;
    incl_hi_o   = incl_w[ADDR_W-1:0];
  end
endmodule

// File: rtl/maint_splitter.sv
module maint_splitter #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int MAX_BYTES  = 1024,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_start_i,
  input  logic [ADDR_W-1:0] req_end_i,
  input  logic              wt_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [1:0]        cmd_op_o,
  output logic [ADDR_W-1:0] cmd_lo_o,
  output logic [ADDR_W-1:0] cmd_hi_o,
  output logic              done_o
);
  import maint_splitter_pkg::*;

  split_state_e    state_q;
  logic [1:0]      kind_q;
  logic            wt_q, need_hi_q;
  logic [ADDR_W-1:0] lo_line_q, hi_line_q;
  logic [ADDR_W:0] cur_q, fin_q;

  logic              a_need_lo, a_need_hi;
  logic [ADDR_W-1:0] a_lo_line, a_hi_line;
  logic [ADDR_W:0]   a_start, a_end;
  logic [ADDR_W:0]   chunk_end;
  logic [ADDR_W-1:0] chunk_hi;
  logic              fire, accept;

  maint_split_align #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_align (
    .kind_i     (req_kind_i),
    .start_i    (req_start_i),
    .end_i      (req_end_i),
    .need_lo_o  (a_need_lo),
    .need_hi_o  (a_need_hi),
    .lo_line_o  (a_lo_line),
    .hi_line_o  (a_hi_line),
    .start_al_o (a_start),
    .end_al_o   (a_end)
  );

  maint_split_chunk #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
    .MAX_BYTES(MAX_BYTES), .PAGE_BYTES(PAGE_BYTES)
  ) u_chunk (
    .cur_i       (cur_q),
    .fin_i       (fin_q),
    .chunk_end_o (chunk_end),
    .incl_hi_o   (chunk_hi)
  );

  // first state of the chunk phase, or done if nothing is left
  function automatic split_state_e chunk_phase(logic [1:0] k, logic wt,
                                               logic [ADDR_W:0] c, logic [ADDR_W:0] f);
    if (c >= f)              return ST_DONE;
    else if (k == KIND_INV)  return ST_INV;
    else if (wt)             return (k == KIND_CLEAN) ? ST_DONE : ST_INV;
    else                     return ST_CLEAN;
  endfunction

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign cmd_valid_o = (state_q == ST_EDGE_LO) || (state_q == ST_EDGE_HI) ||
                       (state_q == ST_CLEAN)   || (state_q == ST_INV);
  assign fire        = cmd_valid_o && cmd_ready_i;
  assign done_o      = (state_q == ST_DONE);

  always_comb begin
    unique case (state_q)
      ST_EDGE_LO: begin cmd_op_o = OP_LINE_CI;   cmd_lo_o = lo_line_q;           cmd_hi_o = lo_line_q; end
      ST_EDGE_HI: begin cmd_op_o = OP_LINE_CI;   cmd_lo_o = hi_line_q;           cmd_hi_o = hi_line_q; end
      ST_CLEAN:   begin cmd_op_o = OP_CLEAN_RNG; cmd_lo_o = cur_q[ADDR_W-1:0];   cmd_hi_o = chunk_hi;  end
      ST_INV:     begin cmd_op_o = OP_INV_RNG;   cmd_lo_o = cur_q[ADDR_W-1:0];   cmd_hi_o = chunk_hi;  end
      default:    begin cmd_op_o = OP_LINE_CI;   cmd_lo_o = '0;                  cmd_hi_o = '0;        end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      kind_q    <= '0;
      wt_q      <= 1'b0;
      need_hi_q <= 1'b0;
      lo_line_q <= '0;
      hi_line_q <= '0;
      cur_q     <= '0;
      fin_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          kind_q    <= req_kind_i;
          wt_q      <= wt_i;
          need_hi_q <= a_need_hi;
          lo_line_q <= a_lo_line;
          hi_line_q <= a_hi_line;
          cur_q     <= a_start;
          fin_q     <= a_end;
          if (a_need_lo)      state_q <= ST_EDGE_LO;
          else if (a_need_hi) state_q <= ST_EDGE_HI;
          else                state_q <= chunk_phase(req_kind_i, wt_i, a_start, a_end);
        end
        ST_EDGE_LO: if (fire)
          state_q <= need_hi_q ? ST_EDGE_HI : chunk_phase(kind_q, wt_q, cur_q, fin_q);
        ST_EDGE_HI: if (fire)
          state_q <= chunk_phase(kind_q, wt_q, cur_q, fin_q);
        ST_CLEAN: if (fire) begin
          if (kind_q == KIND_FLUSH) state_q <= ST_INV;
          else begin
            cur_q   <= chunk_end;
            state_q <= chunk_phase(kind_q, wt_q, chunk_end, fin_q);
          end
        end
        ST_INV: if (fire) begin
          cur_q   <= chunk_end;
          state_q <= chunk_phase(kind_q, wt_q, chunk_end, fin_q);
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/maint_splitter_chk.sv
module maint_splitter_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int MAX_BYTES  = 1024,
  parameter int PAGE_BYTES = 4096
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic [1:0]        cmd_op_o,
  input logic [ADDR_W-1:0] cmd_lo_o,
  input logic [ADDR_W-1:0] cmd_hi_o,
  input logic              done_o,
  input logic              wt_q
);
  localparam int LB = $clog2(LINE_BYTES);
  localparam int PB = $clog2(PAGE_BYTES);

  // R11
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_op_o) &&
                                    $stable(cmd_lo_o) && $stable(cmd_hi_o));
  // R11
  busy_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !req_ready_o);
  // R7
  one_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_lo_o >> PB) == (cmd_hi_o >> PB));
  // R7
  max_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_hi_o >= cmd_lo_o) && (cmd_hi_o - cmd_lo_o < ADDR_W'(MAX_BYTES)));
  // R6
  line_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> cmd_lo_o[LB-1:0] == '0 && cmd_hi_o[LB-1:0] == '0);
  // R2
  line_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_op_o == 2'd0 |-> cmd_lo_o == cmd_hi_o);
  // R9
  wt_no_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_op_o == 2'd1 |-> !wt_q);
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && req_ready_o);
endmodule

bind maint_splitter maint_splitter_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
  .MAX_BYTES(MAX_BYTES), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_ready_i (cmd_ready_i),
  .cmd_op_o    (cmd_op_o),
  .cmd_lo_o    (cmd_lo_o),
  .cmd_hi_o    (cmd_hi_o),
  .done_o      (done_o),
  .wt_q        (wt_q)
);

// File: tb/maint_splitter_tb.sv
module maint_splitter_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_kind = '0;
  logic [AW-1:0] req_start = '0;
  logic [AW-1:0] req_end = '0;
  logic          wt = 1'b0;
  logic          cmd_valid;
  logic          cmd_ready = 1'b0;
  logic [1:0]    cmd_op;
  logic [AW-1:0] cmd_lo, cmd_hi;
  logic          done;

  int checks = 0;
  int fails  = 0;

  typedef struct packed {
    logic [1:0]    op;
    logic [AW-1:0] lo;
    logic [AW-1:0] hi;
  } exp_cmd_t;

  exp_cmd_t exp_q[$];

  always #5 clk = ~clk;

  maint_splitter u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_kind_i(req_kind), .req_start_i(req_start), .req_end_i(req_end),
    .wt_i(wt),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .cmd_op_o(cmd_op), .cmd_lo_o(cmd_lo), .cmd_hi_o(cmd_hi),
    .done_o(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void push(input int op, input longint lo, input longint hi);
    exp_cmd_t c;
    c.op = op[1:0]; c.lo = lo[AW-1:0]; c.hi = hi[AW-1:0];
    exp_q.push_back(c);
  endfunction

  // reference model built from R3..R9
  function automatic void build(input int kind, input bit w, input longint s, input longint e);
    longint ce;
    if (kind == 0) begin
      if (s % 32 != 0) begin push(0, s - s % 32, s - s % 32); s = s - s % 32 + 32; end
      if (s < e && e % 32 != 0) begin push(0, e - e % 32, e - e % 32); e = e - e % 32; end
    end else begin
      s = s - s % 32;
      e = (e + 31) / 32 * 32;
    end
    while (s < e) begin
      ce = e;
      if (s + 1024 < ce) ce = s + 1024;
      if ((s / 4096 + 1) * 4096 < ce) ce = (s / 4096 + 1) * 4096;
      if (kind == 0) push(2, s, ce - 32);
      else if (kind == 1) begin if (!w) push(1, s, ce - 32); end
      else begin
        if (!w) push(1, s, ce - 32);
        push(2, s, ce - 32);
      end
      s = ce;
    end
  endfunction

  task automatic run_req(input int kind, input bit w, input longint s, input longint e);
    bit seen_done = 0;
    exp_q.delete();
    build(kind, w, s, e);
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind[1:0]; wt = w;
    req_start = s[AW-1:0]; req_end = e[AW-1:0];
    @(negedge clk);
    req_valid = 1'b0; wt = $urandom % 2;
    for (int it = 0; it < 5000 && !seen_done; it++) begin
      if (done) begin
        seen_done = 1;
        check(exp_q.size() == 0, "R10 done after last command", exp_q.size(), 0);
        cmd_ready = 1'b0;
      end else begin
        if (cmd_valid) begin
          check(!req_ready, "R11 req_ready low while busy", req_ready, 0);
          if (exp_q.size() == 0) begin
            check(0, "R2 unexpected extra command", cmd_lo, 0);
          end else begin
            check(cmd_op == exp_q[0].op,
                  (kind == 0) ? "R3/R4 op order" : ((kind == 2) ? "R8 flush op order" : "R9 clean op"),
                  cmd_op, exp_q[0].op);
            check(cmd_lo == exp_q[0].lo, "R5/R6 command start", cmd_lo, exp_q[0].lo);
            check(cmd_hi == exp_q[0].hi, "R6/R7 command inclusive end", cmd_hi, exp_q[0].hi);
          end
        end
        cmd_ready = ($urandom % 4) != 0;
        if (cmd_valid && cmd_ready && exp_q.size() != 0) void'(exp_q.pop_front());
        @(negedge clk);
      end
    end
    check(seen_done, "R10 done pulse seen", seen_done, 1);
    @(negedge clk);
    check(!done, "R10 done lasts one cycle", done, 0);
    check(req_ready, "R10 idle after done", req_ready, 1);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #1;
    check(req_ready == 1'b1, "R1 req_ready at reset", req_ready, 1);
    check(cmd_valid == 1'b0, "R1 cmd_valid at reset", cmd_valid, 0);
    check(done == 1'b0, "R1 done at reset", done, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !cmd_valid && !done, "R1 idle after reset", req_ready, 1);

    // directed corners
    run_req(0, 0, 64'h1000, 64'h1000);     // R10 empty invalidate
    run_req(1, 0, 64'h2040, 64'h2040);     // R10 empty clean
    run_req(0, 0, 64'h5, 64'h5);           // R3 unaligned empty: start edge only
    run_req(0, 0, 64'h5, 64'hA);           // R4 end inside same line: no end edge
    run_req(0, 0, 64'h25, 64'h47);         // R3 R4 both edges, no full line
    run_req(0, 0, 64'h1005, 64'h1FF3);     // R3 R4 with full chunks
    run_req(0, 0, 64'h0F00, 64'h1600);     // R6 R7 page cap then length cap
    run_req(1, 0, 64'h3, 64'h2001);        // R5 clean rounding
    run_req(2, 0, 64'h0FE0, 64'h1840);     // R8 flush across page
    run_req(1, 1, 64'h100, 64'h900);       // R9 clean under write-through
    run_req(2, 1, 64'h0FC1, 64'h1422);     // R9 flush under write-through
    run_req(2, 0, 64'h0, 64'h20);          // R8 single line flush
    run_req(1, 0, 64'hFFFF_FF00, 64'hFFFF_FFF1); // R5 end rounds to top of space

    for (int n = 0; n < 300; n++) begin
      longint s, len;
      s   = $urandom % 32'h40000;
      len = (($urandom % 4) == 0) ? $urandom % 70 : $urandom % 4500;
      run_req($urandom % 3, $urandom % 2, s, s + len);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule